// File: doc/BRIEF.md
# Two-Sample Baud-Frame Serializer

This block sends two 16-bit receive samples per baud period over one serial line toward a signal processor. It runs on an oversampling bit clock at 48 times the baud rate. A single-cycle frame-start pulse, synchronous to that clock, stands in for the falling edge of the baud clock. The first slot of each frame carries the most significant bit of the primary sample. The rest of the primary sample follows, most significant bit first. After it come eight zero gap slots, then the interpolated second sample (also most significant bit first), then eight zero tail slots.

On the frame-start edge, both sample words are captured into a shadow register. Any change on the sample inputs after that point has no effect on the frame in progress. A frame-start pulse that arrives while a frame is running restarts the frame at slot 1 with freshly captured words. If a frame reaches slot 48 and no new start has arrived, the line rests at 0 until the next start. The timing margin between the baud clock and the bit clock is an assumption placed on the source of the pulse.

Top module: `baud_pair_serializer`

## Requirements
- R1: While reset is held and after its release before any frame start, `ser_dout` is 0.
- R2: In the first clock cycle after the edge that samples `frame_start` high, `ser_dout` equals bit 15 of `samp_primary` as it was at that edge (slot 1).
- R3: Slots 1 to 16 carry the primary sample from bit 15 down to bit 0, one bit per clock cycle, where slot k carries bit 16-k.
- R4: Slots 17 to 24 (the gap) drive 0.
- R5: Slots 25 to 40 carry the interpolated sample from bit 15 down to bit 0, where slot k carries bit 40-k.
- R6: Slots 41 to 48 drive 0.
- R7: After slot 48, if no new frame start has come, `ser_dout` stays 0 until the next frame start.
- R8: Changes to `samp_primary` or `samp_interp` in cycles where `frame_start` is low do not alter the frame in progress.
- R9: A frame start during a running frame, including one sampled on the slot-48 edge, restarts at slot 1 with the words present at that edge, with no idle slot between frames.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oversampling bit clock (48 per baud) |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | One-cycle pulse marking the baud falling edge |
| samp_primary | input | 16 | Primary sample word, captured at frame start |
| samp_interp | input | 16 | Interpolated sample word, captured at frame start |
| ser_dout | output | 1 | Serial data line |

## Verification
A frame start can coincide with the last slot of the previous frame, or with any slot in the middle of a frame. In that cycle, the counter must choose between wrapping and restarting, and the shadow register must take new words instead of holding the old ones. The bench provokes this by raising the pulse on the slot-48 sampling edge and, in a separate test, at slot 21. It then deserializes the following 48 slots and compares them against a frame image built from the newly supplied words. It also checks that no idle slot appears between the two frames.

// File: rtl/bps_pkg.sv
package bps_pkg;
  localparam int SAMPLE_W = 16;
  localparam int GAP_W    = 8;
  localparam int TAIL_W   = 8;
  localparam int FRAME_SLOTS = 2 * SAMPLE_W + GAP_W + TAIL_W;
  localparam int SLOT_W   = $clog2(FRAME_SLOTS + 1);

  typedef logic [SLOT_W-1:0] slot_t;

  typedef struct packed {
    logic [SAMPLE_W-1:0] primary;
    logic [SAMPLE_W-1:0] interp;
  } sample_pair_t;

  localparam int B_FIRST = SAMPLE_W + GAP_W + 1;
  localparam int B_LAST  = 2 * SAMPLE_W + GAP_W;

  // Bit placed on the line for a given slot (slot 0 means idle).
  function automatic logic slot_bit(input slot_t slot, input sample_pair_t sp);
    int s;
    s = int'(slot);
    if (s >= 1 && s <= SAMPLE_W)
      slot_bit = sp.primary[SAMPLE_W - s];
    else if (s >= B_FIRST && s <= B_LAST)
      slot_bit = sp.interp[B_LAST - s];
    else
      slot_bit = 1'b0;
  endfunction

  function automatic slot_t slot_advance(input slot_t cur, input logic start);
    if (start)
      slot_advance = slot_t'(1);
    else if (cur == '0 || int'(cur) == FRAME_SLOTS)
      slot_advance = '0;
    else
      slot_advance = cur + slot_t'(1);
  endfunction
endpackage

// File: rtl/bps_slot_counter.sv
module bps_slot_counter
  import bps_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  start,
  output slot_t slot_q,
  output slot_t slot_nxt
);
  assign slot_nxt = slot_advance(slot_q, start);

  always_ff @(posedge clk) begin
    if (!rst_n) slot_q <= '0;
    else        slot_q <= slot_nxt;
  end

  // R9
  restart_to_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (slot_q == slot_t'(1)));

  // R3
  slot_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && slot_q != '0 && int'(slot_q) != FRAME_SLOTS)
      |=> (slot_q == $past(slot_q) + slot_t'(1)));

  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && (slot_q == '0 || int'(slot_q) == FRAME_SLOTS)) |=> (slot_q == '0));
endmodule

// File: rtl/bps_shadow.sv
module bps_shadow
  import bps_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  sample_pair_t din,
  output sample_pair_t held,
  output sample_pair_t held_nxt
);
  assign held_nxt = load ? din : held;

  always_ff @(posedge clk) begin
    if (!rst_n) held <= '0;
    else        held <= held_nxt;
  end

  // R8
  shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(held));
endmodule

// File: rtl/bps_line_driver.sv
module bps_line_driver
  import bps_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  slot_t        slot_nxt,
  input  sample_pair_t pair_nxt,
  output logic         dout
);
  logic bit_nxt;
  assign bit_nxt = slot_bit(slot_nxt, pair_nxt);

  always_ff @(posedge clk) begin
    if (!rst_n) dout <= 1'b0;
    else        dout <= bit_nxt;
  end
endmodule

// File: rtl/baud_pair_serializer.sv
module baud_pair_serializer
  import bps_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                frame_start,
  input  logic [SAMPLE_W-1:0] samp_primary,
  input  logic [SAMPLE_W-1:0] samp_interp,
  output logic                ser_dout
);
  slot_t        slot_q, slot_nxt;
  sample_pair_t pair_in, pair_held, pair_nxt;

  assign pair_in.primary = samp_primary;
  assign pair_in.interp  = samp_interp;

  // named event wires for the checks
  logic in_gap, in_tail, idle;
  assign in_gap  = (int'(slot_q) > SAMPLE_W) && (int'(slot_q) < B_FIRST);
  assign in_tail = int'(slot_q) > B_LAST;
  assign idle    = (slot_q == '0);

  bps_slot_counter u_cnt (
    .clk(clk), .rst_n(rst_n), .start(frame_start),
    .slot_q(slot_q), .slot_nxt(slot_nxt)
  );

  bps_shadow u_shadow (
    .clk(clk), .rst_n(rst_n), .load(frame_start),
    .din(pair_in), .held(pair_held), .held_nxt(pair_nxt)
  );

  bps_line_driver u_drv (
    .clk(clk), .rst_n(rst_n), .slot_nxt(slot_nxt),
    .pair_nxt(pair_nxt), .dout(ser_dout)
  );

  // R4
  gap_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_gap |-> (ser_dout == 1'b0));

  // R6
  tail_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_tail |-> (ser_dout == 1'b0));

  // R7
  idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> (ser_dout == 1'b0));

  // R3
  primary_msb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_q == slot_t'(1)) |-> (ser_dout == pair_held.primary[SAMPLE_W-1]));
endmodule

// File: tb/tb_baud_pair_serializer.sv
module tb_baud_pair_serializer;
  localparam time CLK_PERIOD = 10ns;
  localparam int  WATCHDOG_CYC = 20000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_start = 1'b0;
  logic [15:0] samp_primary = '0;
  logic [15:0] samp_interp = '0;
  logic ser_dout;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  baud_pair_serializer dut (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
    .samp_primary(samp_primary), .samp_interp(samp_interp),
    .ser_dout(ser_dout)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input logic act, input logic exp, input string req, input int slot);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s slot %0d: actual %b expected %b", req, slot, act, exp);
    end
  endtask

  function automatic string req_of(input int s);
    if (s == 1) return "R2";
    if (s <= 16) return "R3";
    if (s <= 24) return "R4";
    if (s <= 40) return "R5";
    return "R6";
  endfunction

  // frame image: primary, gap, interp, tail
  function automatic logic exp_bit(input int s, input logic [15:0] a, input logic [15:0] b);
    logic [47:0] img;
    img = {a, 8'h00, b, 8'h00};
    return img[48 - s];
  endfunction

  // Caller sits at a falling edge; returns at the falling edge showing slot 1.
  task automatic start_frame(input logic [15:0] a, input logic [15:0] b);
    frame_start = 1'b1;
    samp_primary = a;
    samp_interp = b;
    @(negedge clk);
    frame_start = 1'b0;
  endtask

  // Checks slots lo..hi; ends at the falling edge of slot hi+1.
  task automatic check_slots(input logic [15:0] a, input logic [15:0] b,
                             input int lo, input int hi, input int chg_at);
    for (int s = lo; s <= hi; s++) begin
      chk(ser_dout, exp_bit(s, a, b), (chg_at > 0) ? "R8" : req_of(s), s);
      if (s == chg_at) begin
        samp_primary = ~a;
        samp_interp = ~b;
      end
      @(negedge clk);
    end
  endtask

  task automatic check_idle(input int n);
    for (int i = 0; i < n; i++) begin
      chk(ser_dout, 1'b0, "R7", 49 + i);
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(ser_dout, 1'b0, "R1", 0);
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(ser_dout, 1'b0, "R1", 0);
    end
  endtask

  task automatic t_basic(input logic [15:0] a, input logic [15:0] b);
    start_frame(a, b);
    check_slots(a, b, 1, 48, 0);
    check_idle(5);
  endtask

  task automatic t_mid_change();
    start_frame(16'h1234, 16'hFEDC);
    check_slots(16'h1234, 16'hFEDC, 1, 48, 10);
    check_idle(2);
  endtask

  task automatic t_restart_mid();
    start_frame(16'hAAAA, 16'h5555);
    check_slots(16'hAAAA, 16'h5555, 1, 20, 0);
    // R9 restart at slot 21
    start_frame(16'h0F0F, 16'hC3A5);
    check_slots(16'h0F0F, 16'hC3A5, 1, 48, 0);
    check_idle(2);
  endtask

  task automatic t_back_to_back();
    start_frame(16'h8001, 16'h7FFE);
    check_slots(16'h8001, 16'h7FFE, 1, 47, 0);
    chk(ser_dout, exp_bit(48, 16'h8001, 16'h7FFE), "R9", 48);
    // R9 start coincides with the slot-48 edge
    start_frame(16'hFFFF, 16'h9669);
    check_slots(16'hFFFF, 16'h9669, 1, 48, 0);
    check_idle(3);
  endtask

  initial begin
    repeat (WATCHDOG_CYC) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    t_reset();
    t_basic(16'hA5C3, 16'h3C81);
    t_basic(16'hFFFF, 16'h0000);
    t_basic(16'h0000, 16'hFFFF);
    t_mid_change();
    t_restart_mid();
    t_back_to_back();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule